// File: doc/BRIEF.md
# Power-Good Strap Latch Sequencer

This block sequences a clock generator's control logic through power-up and power-down. A single input pin serves two purposes. Before power is declared good it acts as a strobe: the first time it is seen high, the block captures the frequency-select straps, two output-routing straps and the test-mode comparator once. From then on the same pin is an active-low power-down request. It is resynchronised into the reference clock domain and has to be confirmed before the clocks are switched off.

When power-down is confirmed, the block either keeps the configuration or wipes it. With wipe selected it pulses a configuration-register reset and returns to the latches-open state, as after a cold start. With keep selected it parks in a powered-down state. A management-mode input forbids the wipe whatever the keep bit says. When the pin is released, the clocks-enable output returns after a programmable number of reference cycles.

Top module: `pgs_top`

## Requirements
- R1: While the asynchronous active-low reset is held, and after its release, latches_open_o is 1 and clk_en_o, cfg_reset_o, test_mode_o, src5_lat_o, itp_lat_o and fs_lat_o are all 0.
- R2: The pin passes through a two-flop synchronizer. A rising pin level driven between clock edges clears latches_open_o only after the third rising clock edge.
- R3: On the edge that leaves the latches-open state, fs_i, src5_strap_i and itp_strap_i are captured into fs_lat_o, src5_lat_o and itp_lat_o.
- R4: Outside test mode, the captured straps do not change for as long as the block stays out of the latches-open state, whatever fs_i and the other strap inputs do.
- R5: fs_vhigh_i is captured into test_mode_o at the same edge. While test mode is set and clocks run, fs_lat_o follows fs_i, one clock later.
- R6: freq_idx_o ranks the CPU frequency selected by fs_lat_o in ascending order. The codes are 100 MHz=0, 133=1, 166=2, 200=3, 266=4, 333=5, 400=6. fs_lat_o maps as 000→266, 001→133, 010→200, 011→166, 100→333, 101→100, 110→400, 111→200.
- R7: Clocks are disabled only when the synchronized pin is low on two consecutive clock edges. A single-cycle low is rejected and clk_en_o stays 1.
- R8: After strap capture or release from power-down, clk_en_o rises exactly RESTART_CYCLES clocks after the block leaves the waiting or powered-down state.
- R9: When keep_cfg_i=0 and mgmt_mode_i=0, a confirmed power-down pulses cfg_reset_o high for exactly one cycle and returns to latches-open. The next pin release captures the straps anew.
- R10: When mgmt_mode_i=1, a confirmed power-down never raises cfg_reset_o and never reopens the latches, even with keep_cfg_i=0.
- R11: When keep_cfg_i=1, a confirmed power-down keeps the captured straps and latches_open_o at 0, and clk_en_o stays 0 until the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset (supply ramp) |
| pg_pdn_i | input | 1 | Dual-function pin: power-good strobe, then active-low power-down |
| fs_i | input | FS_W | Frequency-select strap pins |
| fs_vhigh_i | input | 1 | Upper-threshold comparator of frequency-select bit 2 (test-mode request) |
| src5_strap_i | input | 1 | Strap choosing the SRC5 pair versus stop inputs |
| itp_strap_i | input | 1 | Strap choosing the debug-port CPU clock versus SRC8 |
| keep_cfg_i | input | 1 | 1 keeps configuration across power-down |
| mgmt_mode_i | input | 1 | Management mode; forbids configuration wipe |
| fs_lat_o | output | FS_W | Captured frequency select |
| freq_idx_o | output | 3 | Encoded CPU frequency rank |
| src5_lat_o | output | 1 | Captured SRC5 strap |
| itp_lat_o | output | 1 | Captured debug-port strap |
| test_mode_o | output | 1 | Captured test mode |
| latches_open_o | output | 1 | Waiting for power-good, straps not yet taken |
| clk_en_o | output | 1 | Clocks may run |
| cfg_reset_o | output | 1 | One-cycle configuration register reset |

## Verification
The assertions check on every cycle that the straps hold still unless a capture or test-mode tracking is active, and that tracking copies the previous fs_i. They also check that clocks fall only out of a confirmed pending state, that a wipe pulse coincides with latches-open, that management mode never produces a wipe, and that the restart counter stays in range. The exact synchronizer latency, the restart delay, glitch rejection, the recapture of new straps after a wipe and the full frequency-index table can only be shown by the bench. Its behavioural model is compared with every output on each clock.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_PWRGD   = 3'd0,
    ST_LATCHED_RUN  = 3'd1,
    ST_PD_PENDING   = 3'd2,
    ST_POWERED_DOWN = 3'd3,
    ST_RESTART      = 3'd4
  } pgs_state_e;

  // Rank of the selected CPU frequency, ascending.
  function automatic logic [2:0] fs_to_idx(input logic [2:0] fs);
    logic [2:0] idx;
    case (fs)
      3'b000:  idx = 3'd4;
      3'b001:  idx = 3'd1;
      3'b010:  idx = 3'd3;
      3'b011:  idx = 3'd2;
      3'b100:  idx = 3'd5;
      3'b101:  idx = 3'd0;
      3'b110:  idx = 3'd6;
      default: idx = 3'd3;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d_i;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pgs_strap_latch.sv
module pgs_strap_latch
  import pgs_pkg::*;
#(
  parameter int FS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic            track_i,
  input  logic [FS_W-1:0] fs_i,
  input  logic            vhigh_i,
  input  logic            src5_i,
  input  logic            itp_i,
  output logic [FS_W-1:0] fs_o,
  output logic [2:0]      freq_idx_o,
  output logic            src5_o,
  output logic            itp_o,
  output logic            tm_o
);
  logic [FS_W-1:0] fs_q, fs_d;
  logic            src5_q, src5_d, itp_q, itp_d, tm_q, tm_d;
  logic            fs_en;

  assign fs_en = capture_i | track_i;

  always_comb begin
    fs_d   = fs_en     ? fs_i    : fs_q;
    src5_d = capture_i ? src5_i  : src5_q;
    itp_d  = capture_i ? itp_i   : itp_q;
    tm_d   = capture_i ? vhigh_i : tm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q   <= '0;
      src5_q <= 1'b0;
      itp_q  <= 1'b0;
      tm_q   <= 1'b0;
    end else begin
      fs_q   <= fs_d;
      src5_q <= src5_d;
      itp_q  <= itp_d;
      tm_q   <= tm_d;
    end
  end

  assign fs_o       = fs_q;
  assign freq_idx_o = fs_to_idx(3'(fs_q));
  assign src5_o     = src5_q;
  assign itp_o      = itp_q;
  assign tm_o       = tm_q;

  // R4: straps frozen unless a capture or test-mode tracking is requested
  a_r4_straps_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !track_i) |=> ($stable(fs_q) && $stable(src5_q) && $stable(itp_q) && $stable(tm_q)));

  // R5: tracking copies the frequency-select pins
  a_r5_track_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    track_i |=> (fs_q == $past(fs_i)));
endmodule

// File: rtl/pgs_seq.sv
module pgs_seq
  import pgs_pkg::*;
#(
  parameter int RESTART_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_s_i,
  input  logic keep_cfg_i,
  input  logic mgmt_i,
  input  logic tm_i,
  output logic capture_o,
  output logic track_o,
  output logic latches_open_o,
  output logic clk_en_o,
  output logic cfg_reset_o
);
  localparam int CNT_W = (RESTART_CYCLES > 1) ? $clog2(RESTART_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESTART_CYCLES - 1);

  pgs_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cfgrst_q, cfgrst_d;
  logic             wipe;

  assign wipe = !keep_cfg_i && !mgmt_i;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cfgrst_d = 1'b0;
    case (state_q)
      ST_WAIT_PWRGD: if (pg_s_i) begin
        state_d = ST_RESTART;
        cnt_d   = '0;
      end
      ST_RESTART: if (cnt_q == CNT_LAST) begin
        state_d = ST_LATCHED_RUN;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      ST_LATCHED_RUN: if (!pg_s_i) state_d = ST_PD_PENDING;
      ST_PD_PENDING: begin
        if (pg_s_i) begin
          state_d = ST_LATCHED_RUN;
        end else if (wipe) begin
          state_d  = ST_WAIT_PWRGD;
          cfgrst_d = 1'b1;
        end else begin
          state_d = ST_POWERED_DOWN;
        end
      end
      ST_POWERED_DOWN: if (pg_s_i) begin
        state_d = ST_RESTART;
        cnt_d   = '0;
      end
      default: state_d = ST_WAIT_PWRGD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_WAIT_PWRGD;
      cnt_q    <= '0;
      cfgrst_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      cfgrst_q <= cfgrst_d;
    end
  end

  assign capture_o      = (state_q == ST_WAIT_PWRGD) && pg_s_i;
  assign track_o        = (state_q == ST_LATCHED_RUN) && tm_i;
  assign latches_open_o = (state_q == ST_WAIT_PWRGD);
  assign clk_en_o       = (state_q == ST_LATCHED_RUN) || (state_q == ST_PD_PENDING);
  assign cfg_reset_o    = cfgrst_q;

  // R7: clocks only stop after a confirmed second low sample
  a_r7_two_low_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> ($past(state_q == ST_PD_PENDING) && !$past(pg_s_i)));

  // R9: a wipe pulse lands together with the latches-open state
  a_r9_wipe_reopens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reset_o |-> latches_open_o);

  // R10: management mode never wipes
  a_r10_mgmt_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD_PENDING && !pg_s_i && mgmt_i) |=> (!cfg_reset_o && state_q == ST_POWERED_DOWN));

  // R8: restart counter bounded
  a_r8_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESTART) |-> (cnt_q <= CNT_LAST));
endmodule

// File: rtl/pgs_top.sv
module pgs_top
  import pgs_pkg::*;
#(
  parameter int FS_W           = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int RESTART_CYCLES = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pg_pdn_i,
  input  logic [FS_W-1:0] fs_i,
  input  logic            fs_vhigh_i,
  input  logic            src5_strap_i,
  input  logic            itp_strap_i,
  input  logic            keep_cfg_i,
  input  logic            mgmt_mode_i,
  output logic [FS_W-1:0] fs_lat_o,
  output logic [2:0]      freq_idx_o,
  output logic            src5_lat_o,
  output logic            itp_lat_o,
  output logic            test_mode_o,
  output logic            latches_open_o,
  output logic            clk_en_o,
  output logic            cfg_reset_o
);
  logic pg_s, capture, track, tm;

  pgs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pg_pdn_i), .q_o(pg_s)
  );

  pgs_seq #(.RESTART_CYCLES(RESTART_CYCLES)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pg_s_i        (pg_s),
    .keep_cfg_i    (keep_cfg_i),
    .mgmt_i        (mgmt_mode_i),
    .tm_i          (tm),
    .capture_o     (capture),
    .track_o       (track),
    .latches_open_o(latches_open_o),
    .clk_en_o      (clk_en_o),
    .cfg_reset_o   (cfg_reset_o)
  );

  pgs_strap_latch #(.FS_W(FS_W)) u_straps (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .track_i   (track),
    .fs_i      (fs_i),
    .vhigh_i   (fs_vhigh_i),
    .src5_i    (src5_strap_i),
    .itp_i     (itp_strap_i),
    .fs_o      (fs_lat_o),
    .freq_idx_o(freq_idx_o),
    .src5_o    (src5_lat_o),
    .itp_o     (itp_lat_o),
    .tm_o      (tm)
  );

  assign test_mode_o = tm;
endmodule

// File: tb/pgs_top_tb.sv
module pgs_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic [2:0] fs = 3'b000;
  logic vhigh = 1'b0, src5 = 1'b0, itp = 1'b0, keep = 1'b0, mgmt = 1'b0;
  logic [2:0] fs_lat, fidx;
  logic src5_lat, itp_lat, tmode, lopen, clken, cfgrst;

  int checks = 0, errors = 0;
  bit saw_cfgrst = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgs_top #(.RESTART_CYCLES(RC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pg_pdn_i(pin), .fs_i(fs), .fs_vhigh_i(vhigh),
    .src5_strap_i(src5), .itp_strap_i(itp), .keep_cfg_i(keep), .mgmt_mode_i(mgmt),
    .fs_lat_o(fs_lat), .freq_idx_o(fidx), .src5_lat_o(src5_lat), .itp_lat_o(itp_lat),
    .test_mode_o(tmode), .latches_open_o(lopen), .clk_en_o(clken), .cfg_reset_o(cfgrst)
  );

  // ---- behavioural reference -------------------------------------------
  int mst;               // 0 wait,1 run,2 pending,3 down,4 restart
  int mcnt;
  bit pipe[$];           // pin samples, oldest first
  bit msync;
  bit [2:0] mfs;
  bit msrc5, mitp, mtm, mcfgrst;

  function automatic int mhz(input bit [2:0] f);
    case (f)
      3'd0: return 266; 3'd1: return 133; 3'd2: return 200; 3'd3: return 166;
      3'd4: return 333; 3'd5: return 100; 3'd6: return 400; default: return 200;
    endcase
  endfunction

  function automatic int rank(input bit [2:0] f);
    int list[7] = '{100, 133, 166, 200, 266, 333, 400};
    foreach (list[i]) if (list[i] == mhz(f)) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; mcnt = 0; pipe = '{1'b0, 1'b0}; msync = 0;
      mfs = 0; msrc5 = 0; mitp = 0; mtm = 0; mcfgrst = 0;
    end else begin
      bit s;
      s = pipe[0];           // synchronized value seen at this edge
      void'(pipe.pop_front());
      pipe.push_back(pin);
      mcfgrst = 0;
      if (mst == 0) begin
        if (s) begin mfs = fs; msrc5 = src5; mitp = itp; mtm = vhigh; mst = 4; mcnt = 0; end
      end else if (mst == 4) begin
        mcnt++;
        if (mcnt == RC) begin mst = 1; mcnt = 0; end
      end else if (mst == 1) begin
        if (mtm) mfs = fs;
        if (!s) mst = 2;
      end else if (mst == 2) begin
        if (s) mst = 1;
        else if (!keep && !mgmt) begin mst = 0; mcfgrst = 1; end
        else mst = 3;
      end else begin
        if (s) begin mst = 4; mcnt = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    if (cfgrst) saw_cfgrst = 1;
    chk(fs_lat == mfs,       "R3 fs_lat",       fs_lat,   mfs);
    chk(src5_lat == msrc5,   "R3 src5_lat",     src5_lat, msrc5);
    chk(itp_lat == mitp,     "R3 itp_lat",      itp_lat,  mitp);
    chk(tmode == mtm,        "R5 test_mode",    tmode,    mtm);
    chk(int'(fidx) == rank(fs_lat), "R6 freq_idx", fidx,  rank(fs_lat));
    chk(lopen == (mst == 0), "R2 latches_open", lopen,    mst == 0);
    chk(clken == (mst == 1 || mst == 2), "R7 clk_en", clken, mst == 1 || mst == 2);
    chk(cfgrst == mcfgrst,   "R9 cfg_reset",    cfgrst,   mcfgrst);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    step(3);
    chk(lopen && !clken && !cfgrst && !tmode && fs_lat == 0, "R1 during reset", lopen, 1);
    rst_n = 1'b1;
    step(2);
    chk(lopen && !clken && !cfgrst && !src5_lat && !itp_lat, "R1 after reset", lopen, 1);

    // first power-good: synchronizer latency and capture
    fs = 3'b010; src5 = 1; itp = 0; vhigh = 0;
    pin = 1;
    step(2);
    chk(lopen == 1, "R2 still open after two edges", lopen, 1);
    step(1);
    chk(lopen == 0, "R2 closed after third edge", lopen, 0);
    chk(fs_lat == 3'b010 && src5_lat && !itp_lat, "R3 straps captured", fs_lat, 3'b010);
    step(RC - 1);
    chk(clken == 0, "R8 clocks still off", clken, 0);
    step(1);
    chk(clken == 1, "R8 clocks on after restart count", clken, 1);
    chk(fidx == 3, "R6 200 MHz rank", fidx, 3);

    // one-shot: strap changes ignored
    fs = 3'b111; src5 = 0; itp = 1; vhigh = 1;
    step(5);
    chk(fs_lat == 3'b010 && src5_lat && !itp_lat && !tmode, "R4 straps frozen", fs_lat, 3'b010);
    vhigh = 0;

    // single-cycle low glitch
    pin = 0; step(1); pin = 1;
    step(6);
    chk(clken == 1, "R7 glitch rejected", clken, 1);

    // keep path
    keep = 1; mgmt = 0; saw_cfgrst = 0;
    pin = 0; step(8);
    chk(clken == 0 && lopen == 0, "R11 powered down, latches kept", clken, 0);
    chk(fs_lat == 3'b010 && !saw_cfgrst, "R11 configuration kept", fs_lat, 3'b010);
    pin = 1; step(3 + RC + 1);
    chk(clken == 1, "R11 R8 clocks back", clken, 1);

    // management mode overrides wipe
    keep = 0; mgmt = 1; saw_cfgrst = 0;
    pin = 0; step(8);
    chk(!saw_cfgrst && lopen == 0 && clken == 0, "R10 no wipe in mgmt mode", saw_cfgrst, 0);
    pin = 1; step(3 + RC + 1);
    chk(clken == 1 && fs_lat == 3'b010, "R10 resumes with old straps", fs_lat, 3'b010);

    // wipe path
    mgmt = 0; saw_cfgrst = 0;
    fs = 3'b101; src5 = 0; itp = 1;
    pin = 0; step(8);
    chk(saw_cfgrst && lopen == 1, "R9 wipe and reopen", saw_cfgrst, 1);
    pin = 1; step(3 + RC + 1);
    chk(fs_lat == 3'b101 && itp_lat && !src5_lat, "R9 recapture new straps", fs_lat, 3'b101);
    chk(fidx == 0, "R6 100 MHz rank", fidx, 0);

    // test mode after another wipe
    pin = 0; step(8);
    vhigh = 1; fs = 3'b000;
    pin = 1; step(3 + RC + 1);
    chk(tmode == 1, "R5 test mode captured", tmode, 1);
    vhigh = 0;
    for (int i = 0; i < 8; i++) begin
      fs = 3'(i);
      step(1);
      chk(fs_lat == 3'(i), "R5 fs tracks in test mode", fs_lat, i);
      chk(int'(fidx) == rank(3'(i)), "R6 frequency rank", fidx, rank(3'(i)));
    end

    step(4);
    finish_run();
  end
endmodule